// File: doc/BRIEF.md
# DMA Write Handshake Controller

This block is the slave end of a DMA write transfer that fills a transmit message buffer for an HDLC framer. It raises a request to an external DMA controller. Once the controller answers on an active-low acknowledge line, the block takes one byte from the 8-bit data bus for each low pulse of an active-low write strobe. Each byte goes into a local buffer at the current write pointer.

The block decides on its own when the transfer ends. The transfer ends when the programmed length is reached, or when the buffer location at the top of the buffer has been written. The block drops its request inside the strobe that carries that final byte. It then waits for the controller to release acknowledge, pulses a done flag and goes back to idle.

The acknowledge and strobe inputs are asynchronous and pass through a two-stage synchronizer. The framing logic reads the buffer through a registered read port. It empties the buffer by clearing the write pointer while the block is idle.

Top module: `txbuf_dma_fill`

## Requirements
- R1: After synchronous reset, `dma_req` is 0, `done` is 0 and `wr_ptr` is 0.
- R2: While idle, the block raises `dma_req` one clock after it sees all of the following at a clock edge: `enable` is 1, synchronized `dma_ack_n` is 1, and `wr_ptr` is below DEPTH. If `wr_ptr` equals DEPTH (buffer full), the request stays 0.
- R3: While the request is active and synchronized `dma_ack_n` is 0, each falling edge of `dma_wr_n` writes `dma_data` to buffer location `wr_ptr` and increments `wr_ptr` by exactly 1. The update is visible three clocks after the strobe falls. `rd_data` returns the byte at `rd_addr` one clock after the address is applied.
- R4: A strobe that falls while `dma_ack_n` is 1 has no effect, and `wr_ptr` is unchanged.
- R5: When `xfer_len` is nonzero, it is latched as the request rises. The strobe that writes byte number `xfer_len` of the transfer also drops `dma_req` in the same clock as the pointer update, while `dma_wr_n` is still low.
- R6: The strobe that writes location DEPTH-1 drops `dma_req` in the same way, whatever the length. An `xfer_len` of 0 means the transfer ends only when the buffer is full. `wr_ptr` never exceeds DEPTH.
- R7: After the request is dropped, further strobes are ignored. `dma_req` stays 0 until synchronized `dma_ack_n` has been seen at 1.
- R8: `done` is high for exactly one clock, three clocks after `dma_ack_n` rises at the end of a transfer. The block is then idle and may raise `dma_req` on the following clock.
- R9: `buf_clr` sets `wr_ptr` to 0 when the block is idle. It is ignored while a transfer is in progress.
- R10: With `enable` at 0, `dma_req` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous reset, active high |
| enable | input | 1 | Allows new transfers to start |
| xfer_len | input | PW (5) | Bytes per transfer; 0 means fill the buffer |
| buf_clr | input | 1 | Empties the buffer (honoured when idle) |
| dma_req | output | 1 | DMA request, active high |
| dma_ack_n | input | 1 | DMA acknowledge, active low, asynchronous |
| dma_wr_n | input | 1 | Write strobe, active low, asynchronous |
| dma_data | input | DW (8) | Write data bus |
| done | output | 1 | One-clock pulse at the end of a transfer |
| wr_ptr | output | PW (5) | Buffer fill level and next write location |
| rd_addr | input | AW (4) | Buffer read address from the framer |
| rd_data | output | DW (8) | Buffer read data, one clock latency |

## Verification
Two functions share one clock edge: capturing the final byte, and dropping the request. The final byte is either the last byte of a programmed length or the byte that fills the top buffer location. The bench provokes both cases with a length of three bytes and with a length of zero that fills the buffer. At the third sample after the strobe falls, it requires the advanced pointer and the low request together, while it is still holding the strobe low. Straggling strobes sent after the drop must leave the pointer where it is. The request must not return until acknowledge has been released.

// File: rtl/txbuf_dma_pkg.sv
package txbuf_dma_pkg;
  typedef enum logic [1:0] {
    XS_IDLE = 2'd0,
    XS_BUSY = 2'd1,
    XS_DRAIN = 2'd2
  } xfer_state_t;
endpackage

// File: rtl/txbuf_dma_sync.sv
module txbuf_dma_sync #(
  parameter int W      = 2,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] async_in,
  output logic [W-1:0] sync_out
);
  logic [W-1:0] stg [STAGES];

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) stg[0] <= RST_VAL;
          else     stg[0] <= async_in;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) stg[g] <= RST_VAL;
          else     stg[g] <= stg[g-1];
        end
      end
    end
  endgenerate

  assign sync_out = stg[STAGES-1];
endmodule

// File: rtl/txbuf_dma_store.sv
module txbuf_dma_store #(
  parameter int DW    = 8,
  parameter int DEPTH = 16,
  localparam int AW   = $clog2(DEPTH),
  localparam int PW   = AW + 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic [DW-1:0] wdata,
  input  logic          clr,
  input  logic [AW-1:0] rd_addr,
  output logic [PW-1:0] wr_ptr,
  output logic [DW-1:0] rd_data
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[wr_ptr[AW-1:0]] <= wdata;
    rd_data <= mem[rd_addr];
  end

  always_ff @(posedge clk) begin
    if (rst)      wr_ptr <= '0;
    else if (clr) wr_ptr <= '0;
    else if (we)  wr_ptr <= wr_ptr + PW'(1);
  end

  assert_no_overflow_R6: assert property (@(posedge clk) disable iff (rst)
    wr_ptr <= PW'(DEPTH));
  assert_write_room_R6: assert property (@(posedge clk) disable iff (rst)
    we |-> (wr_ptr < PW'(DEPTH)));
  assert_ptr_step_R3: assert property (@(posedge clk) disable iff (rst)
    (wr_ptr != $past(wr_ptr)) |-> ((wr_ptr == $past(wr_ptr) + PW'(1)) || (wr_ptr == '0)));
endmodule

// File: rtl/txbuf_dma_ctrl.sv
module txbuf_dma_ctrl
  import txbuf_dma_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int PW   = $clog2(DEPTH) + 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          enable,
  input  logic [PW-1:0] xfer_len,
  input  logic          buf_clr,
  input  logic          ack_s,
  input  logic          wr_s,
  input  logic [PW-1:0] wr_ptr,
  output logic          dma_req,
  output logic          done,
  output logic          we,
  output logic          clr
);
  xfer_state_t st;
  logic          wr_q;
  logic [PW-1:0] len_q;
  logic [PW-1:0] cnt_q;
  logic          wr_fall;
  logic          full;
  logic          last;

  assign wr_fall = wr_q & ~wr_s;
  assign full    = (wr_ptr == PW'(DEPTH));
  assign we      = (st == XS_BUSY) && wr_fall && !ack_s;
  assign clr     = buf_clr && (st == XS_IDLE);
  assign last    = (wr_ptr == PW'(DEPTH - 1)) ||
                   ((len_q != '0) && (cnt_q + PW'(1) == len_q));

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= XS_IDLE;
      dma_req <= 1'b0;
      done    <= 1'b0;
      wr_q    <= 1'b1;
      len_q   <= '0;
      cnt_q   <= '0;
    end else begin
      done <= 1'b0;
      wr_q <= wr_s;
      case (st)
        XS_IDLE: begin
          if (enable && !full && ack_s) begin
            st      <= XS_BUSY;
            dma_req <= 1'b1;
            len_q   <= xfer_len;
            cnt_q   <= '0;
          end
        end
        XS_BUSY: begin
          if (we) begin
            cnt_q <= cnt_q + PW'(1);
            if (last) begin
              dma_req <= 1'b0;
              st      <= XS_DRAIN;
            end
          end
        end
        XS_DRAIN: begin
          if (ack_s) begin
            done <= 1'b1;
            st   <= XS_IDLE;
          end
        end
        default: st <= XS_IDLE;
      endcase
    end
  end

  assert_req_rise_R2: assert property (@(posedge clk) disable iff (rst)
    $rose(dma_req) |-> ($past(enable) && $past(ack_s)));
  assert_req_fall_in_strobe_R5: assert property (@(posedge clk) disable iff (rst)
    $fell(dma_req) |-> $past(!wr_s));
  assert_hold_until_ack_R7: assert property (@(posedge clk) disable iff (rst)
    ((st == XS_DRAIN) && !ack_s) |=> !dma_req);
  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  assert_idle_no_enable_R10: assert property (@(posedge clk) disable iff (rst)
    ((st == XS_IDLE) && !enable) |=> !dma_req);
endmodule

// File: rtl/txbuf_dma_fill.sv
module txbuf_dma_fill #(
  parameter int DW     = 8,
  parameter int DEPTH  = 16,
  parameter int STAGES = 2,
  localparam int AW    = $clog2(DEPTH),
  localparam int PW    = AW + 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          enable,
  input  logic [PW-1:0] xfer_len,
  input  logic          buf_clr,
  output logic          dma_req,
  input  logic          dma_ack_n,
  input  logic          dma_wr_n,
  input  logic [DW-1:0] dma_data,
  output logic          done,
  output logic [PW-1:0] wr_ptr,
  input  logic [AW-1:0] rd_addr,
  output logic [DW-1:0] rd_data
);
  logic [1:0] sync_o;
  logic       we;
  logic       clr;

  txbuf_dma_sync #(.W(2), .STAGES(STAGES), .RST_VAL(2'b11)) u_sync (
    .clk      (clk),
    .rst      (rst),
    .async_in ({dma_ack_n, dma_wr_n}),
    .sync_out (sync_o)
  );

  txbuf_dma_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .enable   (enable),
    .xfer_len (xfer_len),
    .buf_clr  (buf_clr),
    .ack_s    (sync_o[1]),
    .wr_s     (sync_o[0]),
    .wr_ptr   (wr_ptr),
    .dma_req  (dma_req),
    .done     (done),
    .we       (we),
    .clr      (clr)
  );

  txbuf_dma_store #(.DW(DW), .DEPTH(DEPTH)) u_store (
    .clk     (clk),
    .rst     (rst),
    .we      (we),
    .wdata   (dma_data),
    .clr     (clr),
    .rd_addr (rd_addr),
    .wr_ptr  (wr_ptr),
    .rd_data (rd_data)
  );
endmodule

// File: tb/txbuf_dma_fill_tb_top.sv
module txbuf_dma_fill_tb_top;
  localparam int DW = 8;
  localparam int DEPTH = 16;
  localparam int AW = $clog2(DEPTH);
  localparam int PW = AW + 1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic enable = 1'b0;
  logic [PW-1:0] xfer_len = '0;
  logic buf_clr = 1'b0;
  logic dma_req;
  logic dma_ack_n = 1'b1;
  logic dma_wr_n = 1'b1;
  logic [DW-1:0] dma_data = '0;
  logic done;
  logic [PW-1:0] wr_ptr;
  logic [AW-1:0] rd_addr = '0;
  logic [DW-1:0] rd_data;

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;

  always #2.5 clk = ~clk;

  txbuf_dma_fill #(.DW(DW), .DEPTH(DEPTH)) dut_i (
    .clk(clk), .rst(rst), .enable(enable), .xfer_len(xfer_len),
    .buf_clr(buf_clr), .dma_req(dma_req), .dma_ack_n(dma_ack_n),
    .dma_wr_n(dma_wr_n), .dma_data(dma_data), .done(done),
    .wr_ptr(wr_ptr), .rd_addr(rd_addr), .rd_data(rd_data)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Strobe low for 5 clocks; sample pointer and request 3 clocks after the fall.
  task automatic strobe(input logic [DW-1:0] d, output int p_mid, output int r_mid);
    dma_data = d;
    dma_wr_n = 1'b0;
    tick(3);
    p_mid = int'(wr_ptr);
    r_mid = int'(dma_req);
    tick(2);
    dma_wr_n = 1'b1;
    tick(3);
  endtask

  task automatic t_reset;
    tick(3);
    rst = 1'b0;
    tick(1);
    check(dma_req == 1'b0, "R1 req", int'(dma_req), 0);
    check(done == 1'b0, "R1 done", int'(done), 0);
    check(wr_ptr == '0, "R1 ptr", int'(wr_ptr), 0);
  endtask

  task automatic t_disabled;
    tick(5);
    check(dma_req == 1'b0, "R10 req while disabled", int'(dma_req), 0);
  endtask

  task automatic t_length_xfer;
    int p, r;
    xfer_len = PW'(3);
    enable = 1'b1;
    tick(2);
    check(dma_req == 1'b1, "R2 req raised", int'(dma_req), 1);
    strobe(8'hEE, p, r);
    check(p == 0, "R4 strobe without ack ignored", p, 0);
    dma_ack_n = 1'b0;
    tick(3);
    strobe(8'hA1, p, r);
    check(p == 1 && r == 1, "R3 first byte", p * 10 + r, 11);
    strobe(8'hB2, p, r);
    check(p == 2 && r == 1, "R3 second byte", p * 10 + r, 21);
    strobe(8'hC3, p, r);
    check(p == 3, "R5 last byte ptr", p, 3);
    check(r == 0, "R5 req dropped inside strobe", r, 0);
    strobe(8'hD4, p, r);
    check(p == 3, "R7 strobe after drop ignored", p, 3);
    check(dma_req == 1'b0, "R7 req held low", int'(dma_req), 0);
    xfer_len = '0;
    dma_ack_n = 1'b1;
    tick(2);
    check(done == 1'b0 && dma_req == 1'b0, "R7 no early done/req", int'(done) + int'(dma_req), 0);
    tick(1);
    check(done == 1'b1, "R8 done pulse", int'(done), 1);
    check(dma_req == 1'b0, "R8 req low with done", int'(dma_req), 0);
    tick(1);
    check(done == 1'b0, "R8 done one clock", int'(done), 0);
    check(dma_req == 1'b1, "R8 re-request", int'(dma_req), 1);
    for (int i = 0; i < 3; i++) begin
      logic [DW-1:0] exp_b;
      exp_b = (i == 0) ? 8'hA1 : (i == 1) ? 8'hB2 : 8'hC3;
      rd_addr = AW'(i);
      tick(1);
      check(rd_data == exp_b, "R3 buffer readback", int'(rd_data), int'(exp_b));
    end
  endtask

  task automatic t_fill_full;
    int p, r;
    dma_ack_n = 1'b0;
    tick(3);
    for (int i = 3; i < DEPTH; i++) begin
      strobe(DW'(8'h40 + i), p, r);
      check(p == i + 1, "R3 fill ptr", p, i + 1);
      if (i < DEPTH - 1) check(r == 1, "R6 req kept before top", r, 1);
      else               check(r == 0, "R6 req dropped at top", r, 0);
    end
    strobe(8'h99, p, r);
    check(p == DEPTH, "R6 no overflow", p, DEPTH);
    dma_ack_n = 1'b1;
    tick(6);
    check(dma_req == 1'b0, "R2 no req when full", int'(dma_req), 0);
    rd_addr = AW'(DEPTH - 1);
    tick(1);
    check(rd_data == DW'(8'h40 + DEPTH - 1), "R3 top byte", int'(rd_data), 8'h40 + DEPTH - 1);
  endtask

  task automatic t_clear;
    int p, r;
    buf_clr = 1'b1;
    tick(1);
    buf_clr = 1'b0;
    check(wr_ptr == '0, "R9 clear in idle", int'(wr_ptr), 0);
    tick(2);
    check(dma_req == 1'b1, "R2 req after clear", int'(dma_req), 1);
    dma_ack_n = 1'b0;
    tick(3);
    strobe(8'h5A, p, r);
    check(p == 1, "R3 byte after clear", p, 1);
    buf_clr = 1'b1;
    tick(1);
    buf_clr = 1'b0;
    tick(1);
    check(wr_ptr == PW'(1), "R9 clear ignored in transfer", int'(wr_ptr), 1);
  endtask

  initial begin
    fork
      begin
        t_reset();
        t_disabled();
        t_length_xfer();
        t_fill_full();
        t_clear();
      end
      begin
        while (cyc < 20000) @(posedge clk) cyc++;
        check(1'b0, "watchdog", cyc, 0);
      end
    join_any
    disable fork;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule